// File: doc/BRIEF.md
# Software-Loaded TLB Address Translator

This block sits between a processor's memory master port and a downstream memory port. In user mode it maps each virtual word address to a physical one. The mapping comes from a small, fully associative translation buffer that software fills one entry at a time through a separate setup port. Each entry holds a virtual page number, a physical page number, a process context tag and four flag bits. The context tag is split: its low half lives in the virtual word and its high half in the physical word, in the bit field just above the flags and below the page boundary.

Each master strobe is registered into a single lookup stage. Its translation is decided combinationally in the next cycle. A hit forwards the strobe downstream in that cycle. A lookup that finds no entry, that writes a read-only page, or that fetches an instruction from a page without execute rights is answered with a miss pulse instead of a memory cycle. Software then refills the buffer. When the user-mode input is low, addresses go through unchanged and no permission checks are made. Back-to-back strobes are accepted at one per cycle, so a burst inside a mapped page runs without stalls.

Top module: `tlb_mmu`

## Requirements
- R1: Setup word 0 reads as {address width - 17, log2 entries, log2 page bytes - 10, context width - 1, context}, one 4-bit field each for the first four (bits 31:28 down to 19:16), with the context in the low 16 bits. With the defaults it reads 0xF32F_0000 plus the context. Only the context bits take a write; the other bits keep their values.
- R2: Every setup access accepted on a clock edge (strobe high, stall low) is acknowledged in the cycle after that edge, and a read returns its data in that same cycle.
- R3: The setup port reports stall in every cycle that a master request occupies the lookup stage.
- R4: Reset leaves every entry invalid, so no access misses being caught by an all-zero entry. A write to an entry's virtual word (setup word 2^(E+1)+2K, where E is log2 entries) makes entry K valid. A write to its physical word goes to word 2^(E+1)+2K+1. Reads return the stored words, and the physical word reads its low 4 bits as zero.
- R5: A user-mode access that matches no valid entry raises the miss output for one cycle, in the second cycle after the accepting edge. The error output stays low and no memory strobe is issued. Setup word 1 then reads the faulting byte address.
- R6: A user-mode write to an entry with flag bit 3 (read-only) set is a miss. A read of that entry is forwarded.
- R7: A user-mode access with the execute input high, to an entry without flag bit 2 (executable) set, is a miss. The same access to an entry with bit 2 set is forwarded.
- R8: A user-mode hit drives the memory strobe in the cycle right after the accepting edge. The address is the entry's physical page number joined to the untouched in-page word offset, and write enable, write data and byte selects are those of the request.
- R9: Strobes to a mapped page on consecutive cycles are accepted without master stall. A downstream stall holds the memory address steady and stalls the master until the stall is released, and no request is lost.
- R10: With the user-mode input low, the memory address equals the request address and no miss is raised, even for writes to read-only pages.
- R11: Flag bit 0 (accessed) of an entry becomes 1 on its first forwarded user-mode hit and stays 1 until software rewrites the virtual word.
- R12: A hit needs both halves of the current context to match: the low half against the virtual word's tag field and the high half against the physical word's tag field.
- R13: Memory acknowledge, error and read data reach the master outputs in the same cycle they arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_cfg_stb | input | 1 | Setup access strobe |
| i_cfg_we | input | 1 | Setup write enable |
| i_cfg_addr | input | LG_ENT+2 | Setup word address |
| i_cfg_wdata | input | 32 | Setup write data |
| o_cfg_stall | output | 1 | Setup port busy |
| o_cfg_ack | output | 1 | Setup acknowledge |
| o_cfg_rdata | output | 32 | Setup read data |
| i_user | input | 1 | User mode: translate and check |
| i_exe | input | 1 | Access is an instruction fetch |
| i_req_stb | input | 1 | Master strobe |
| i_req_we | input | 1 | Master write enable |
| i_req_addr | input | 30 | Master virtual word address |
| i_req_wdata | input | 32 | Master write data |
| i_req_sel | input | 4 | Master byte selects |
| o_req_stall | output | 1 | Master stall |
| o_req_ack | output | 1 | Master acknowledge |
| o_req_miss | output | 1 | Translation miss or permission fault |
| o_req_err | output | 1 | Bus error from memory |
| o_req_rdata | output | 32 | Master read data |
| o_mem_stb | output | 1 | Memory strobe |
| o_mem_we | output | 1 | Memory write enable |
| o_mem_addr | output | 30 | Memory physical word address |
| o_mem_wdata | output | 32 | Memory write data |
| o_mem_sel | output | 4 | Memory byte selects |
| i_mem_stall | input | 1 | Memory stall |
| i_mem_ack | input | 1 | Memory acknowledge |
| i_mem_err | input | 1 | Memory error |
| i_mem_rdata | input | 32 | Memory read data |

## Verification
A master request accepted on edge N has its memory strobe in the cycle after N, when it hits. Otherwise its miss pulse comes in the cycle after N+1. With the bench memory answering one cycle after it takes a strobe, every request's acknowledge or miss therefore lands in the same cycle after N+1, and the results stay in request order. The bench pushes, per request, an expected memory item (physical address, direction, data) and an expected master item (miss or acknowledge with data) into queues. Two monitors sample half a cycle away from the edges and pop and compare. A setup access accepted on edge N is checked for its acknowledge and data in the cycle after N.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  // Setup words and entry words are this wide, as is the byte address.
  localparam int BUS_W = 32;
  // Flag positions in the low nibble of an entry's virtual word.
  localparam int FL_AC = 0;
  localparam int FL_CH = 1;
  localparam int FL_EX = 2;
  localparam int FL_RO = 3;
  localparam int FLAG_W = 4;
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
  import mmu_pkg::*;
#(
  parameter int LG_PG = 12
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   wr_virt,
  input  logic                   wr_phys,
  input  logic [BUS_W-1:0]       wdata,
  input  logic                   mark_acc,
  input  logic [BUS_W-LG_PG-1:0] look_vpn,
  input  logic [LG_PG-5:0]       look_clo,
  input  logic [LG_PG-5:0]       look_chi,
  output logic                   hit,
  output logic [BUS_W-1:0]       vword,
  output logic [BUS_W-1:0]       pword
);
  logic             valid_q, valid_n;
  logic [BUS_W-1:0] vw_q, vw_n, pw_q, pw_n;
  logic             en;

  always_comb begin
    valid_n = valid_q | wr_virt;
    vw_n    = vw_q;
    if (wr_virt)       vw_n = wdata;
    else if (mark_acc) vw_n[FL_AC] = 1'b1;
    pw_n = wr_phys ? {wdata[BUS_W-1:FLAG_W], {FLAG_W{1'b0}}} : pw_q;
    en   = wr_virt | wr_phys | mark_acc;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vw_q    <= '0;
      pw_q    <= '0;
    end else if (en) begin
      valid_q <= valid_n;
      vw_q    <= vw_n;
      pw_q    <= pw_n;
    end
  end

  assign hit = valid_q
             && (vw_q[BUS_W-1:LG_PG] == look_vpn)
             && (vw_q[LG_PG-1:FLAG_W] == look_clo)
             && (pw_q[LG_PG-1:FLAG_W] == look_chi);
  assign vword = vw_q;
  assign pword = pw_q;

  // R4: a virtual-word write leaves the entry valid
  a_r4_write_validates: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_virt |=> valid_q);
  // R11: the accessed flag is sticky until software rewrites the word
  a_r11_acc_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_q && vw_q[FL_AC] && !wr_virt) |=> vw_q[FL_AC]);
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);
  // Lowest-numbered matching entry wins when software leaves duplicates.
  always_comb begin
    onehot = '0;
    idx    = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hits[k]) begin
        onehot    = '0;
        onehot[k] = 1'b1;
        idx       = IW'(k);
      end
    end
  end
  assign any = |hits;
endmodule

// File: rtl/tlb_mmu.sv
module tlb_mmu
  import mmu_pkg::*;
#(
  parameter int LG_ENT = 3,
  parameter int LG_PG  = 12,
  parameter int CTX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_cfg_stb,
  input  logic              i_cfg_we,
  input  logic [LG_ENT+1:0] i_cfg_addr,
  input  logic [31:0]       i_cfg_wdata,
  output logic              o_cfg_stall,
  output logic              o_cfg_ack,
  output logic [31:0]       o_cfg_rdata,
  input  logic              i_user,
  input  logic              i_exe,
  input  logic              i_req_stb,
  input  logic              i_req_we,
  input  logic [29:0]       i_req_addr,
  input  logic [31:0]       i_req_wdata,
  input  logic [3:0]        i_req_sel,
  output logic              o_req_stall,
  output logic              o_req_ack,
  output logic              o_req_miss,
  output logic              o_req_err,
  output logic [31:0]       o_req_rdata,
  output logic              o_mem_stb,
  output logic              o_mem_we,
  output logic [29:0]       o_mem_addr,
  output logic [31:0]       o_mem_wdata,
  output logic [3:0]        o_mem_sel,
  input  logic              i_mem_stall,
  input  logic              i_mem_ack,
  input  logic              i_mem_err,
  input  logic [31:0]       i_mem_rdata
);
  localparam int N     = 1 << LG_ENT;
  localparam int WAW   = BUS_W - 2;
  localparam int PO_W  = LG_PG - 2;
  localparam int VPN_W = BUS_W - LG_PG;
  localparam int FLD_W = LG_PG - FLAG_W;
  localparam int CA_W  = LG_ENT + 2;

  // ---------------- reset: asynchronous assert, synchronous release
  logic [1:0] rst_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  // ---------------- lookup stage
  logic             r_valid, r_valid_n, load;
  logic             r_we, r_user, r_exe;
  logic [WAW-1:0]   r_addr;
  logic [31:0]      r_wdata;
  logic [3:0]       r_sel;
  logic [CTX_W-1:0] r_ctx, ctx_n;
  logic [WAW-1:0]   r_stat, stat_n;
  logic             r_miss, miss_n;

  logic [N-1:0]       hits, onehot, wr_v, wr_p, mark;
  logic               hit_any, deny, sel_ro, sel_ex;
  logic [LG_ENT-1:0]  pidx;
  logic [BUS_W-1:0]   vw_a [N];
  logic [BUS_W-1:0]   pw_a [N];
  logic [FLD_W-1:0]   look_clo, look_chi;

  assign look_clo = r_ctx[FLD_W-1:0];
  assign look_chi = FLD_W'(r_ctx >> FLD_W);

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_slot
      tlb_slot #(.LG_PG(LG_PG)) u_slot (
        .clk      (clk),
        .rst_ni   (rst_ni),
        .wr_virt  (wr_v[k]),
        .wr_phys  (wr_p[k]),
        .wdata    (i_cfg_wdata),
        .mark_acc (mark[k]),
        .look_vpn (r_addr[WAW-1:PO_W]),
        .look_clo (look_clo),
        .look_chi (look_chi),
        .hit      (hits[k]),
        .vword    (vw_a[k]),
        .pword    (pw_a[k])
      );
    end
  endgenerate

  tlb_pick #(.N(N), .IW(LG_ENT)) u_pick (
    .hits   (hits),
    .any    (hit_any),
    .onehot (onehot),
    .idx    (pidx)
  );

  assign sel_ro = vw_a[pidx][FL_RO];
  assign sel_ex = vw_a[pidx][FL_EX];

  always_comb begin
    deny        = r_user & (~hit_any | (r_we & sel_ro) | (r_exe & ~sel_ex));
    o_mem_stb   = r_valid & ~deny;
    o_mem_addr  = r_user ? {pw_a[pidx][BUS_W-1:LG_PG], r_addr[PO_W-1:0]} : r_addr;
    o_req_stall = o_mem_stb & i_mem_stall;
    load        = i_req_stb & ~o_req_stall;
    r_valid_n   = o_req_stall ? r_valid : i_req_stb;
    miss_n      = r_valid & deny;
    stat_n      = miss_n ? r_addr : r_stat;
    for (int j = 0; j < N; j++)
      mark[j] = o_mem_stb & r_user & onehot[j] & ~i_mem_stall;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      r_valid <= 1'b0;
      r_we    <= 1'b0;
      r_user  <= 1'b0;
      r_exe   <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_sel   <= '0;
      r_miss  <= 1'b0;
      r_stat  <= '0;
    end else begin
      r_valid <= r_valid_n;
      r_miss  <= miss_n;
      r_stat  <= stat_n;
      if (load) begin
        r_we    <= i_req_we;
        r_user  <= i_user;
        r_exe   <= i_exe;
        r_addr  <= i_req_addr;
        r_wdata <= i_req_wdata;
        r_sel   <= i_req_sel;
      end
    end
  end

  assign o_mem_we    = r_we;
  assign o_mem_wdata = r_wdata;
  assign o_mem_sel   = r_sel;
  assign o_req_miss  = r_miss;
  assign o_req_ack   = i_mem_ack;
  assign o_req_err   = i_mem_err;
  assign o_req_rdata = i_mem_rdata;

  // ---------------- setup port
  logic              cfg_acc, tbl, cphy, wr_ctx, ack_n;
  logic [LG_ENT-1:0] cidx;
  logic [31:0]       rd_n, ctl_word;

  always_comb begin
    cfg_acc  = i_cfg_stb & ~r_valid;
    tbl      = i_cfg_addr[CA_W-1];
    cphy     = i_cfg_addr[0];
    cidx     = i_cfg_addr[LG_ENT:1];
    wr_ctx   = cfg_acc & i_cfg_we & ~tbl & (i_cfg_addr[CA_W-2:0] == '0);
    ctx_n    = wr_ctx ? i_cfg_wdata[CTX_W-1:0] : r_ctx;
    ack_n    = cfg_acc;
    ctl_word = {4'(BUS_W - 17), 4'(LG_ENT), 4'(LG_PG - 10), 4'(CTX_W - 1), 16'(r_ctx)};
    for (int j = 0; j < N; j++) begin
      wr_v[j] = cfg_acc & i_cfg_we & tbl & ~cphy & (cidx == LG_ENT'(j));
      wr_p[j] = cfg_acc & i_cfg_we & tbl &  cphy & (cidx == LG_ENT'(j));
    end
    if (tbl)                             rd_n = cphy ? pw_a[cidx] : vw_a[cidx];
    else if (i_cfg_addr[CA_W-2:0] == 0)  rd_n = ctl_word;
    else if (i_cfg_addr[CA_W-2:0] == 1)  rd_n = {r_stat, 2'b00};
    else                                 rd_n = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      r_ctx       <= '0;
      o_cfg_ack   <= 1'b0;
      o_cfg_rdata <= '0;
    end else begin
      r_ctx     <= ctx_n;
      o_cfg_ack <= ack_n;
      if (cfg_acc) o_cfg_rdata <= rd_n;
    end
  end

  assign o_cfg_stall = r_valid;

  // R2: acknowledge exactly one cycle after an accepted setup strobe
  a_r2_cfg_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_acc |=> o_cfg_ack);
  a_r2_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    !cfg_acc |=> !o_cfg_ack);
  // R5: a miss never follows a cycle that issued a memory strobe
  a_r5_miss_no_mem: assert property (@(posedge clk) disable iff (!rst_ni)
    o_req_miss |-> !$past(o_mem_stb));
  // R9: a stalled memory strobe keeps its address
  a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(o_mem_stb && i_mem_stall) && o_mem_stb) |-> $stable(o_mem_addr));
endmodule

// File: tb/tlb_mmu_tb.sv
module tlb_mmu_tb;
  localparam int LG_ENT = 3;
  localparam int LG_PG  = 12;
  localparam int CTX_W  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        c_stb = 0, c_we = 0;
  logic [4:0]  c_addr = '0;
  logic [31:0] c_wdata = '0;
  logic        m_user = 0, m_exe = 0, m_stb = 0, m_we = 0;
  logic [29:0] m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic [3:0]  m_sel = 4'hF;
  logic        mem_stall = 0, mem_ack, mem_err = 0;
  logic [31:0] mem_rdata;

  logic        o_cfg_stall, o_cfg_ack, o_req_stall, o_req_ack, o_req_miss, o_req_err;
  logic [31:0] o_cfg_rdata, o_req_rdata, o_mem_wdata;
  logic        o_mem_stb, o_mem_we;
  logic [29:0] o_mem_addr;
  logic [3:0]  o_mem_sel;

  always #10 clk = ~clk;  // 50 MHz

  tlb_mmu #(.LG_ENT(LG_ENT), .LG_PG(LG_PG), .CTX_W(CTX_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .i_cfg_stb(c_stb), .i_cfg_we(c_we), .i_cfg_addr(c_addr), .i_cfg_wdata(c_wdata),
    .o_cfg_stall(o_cfg_stall), .o_cfg_ack(o_cfg_ack), .o_cfg_rdata(o_cfg_rdata),
    .i_user(m_user), .i_exe(m_exe), .i_req_stb(m_stb), .i_req_we(m_we),
    .i_req_addr(m_addr), .i_req_wdata(m_wdata), .i_req_sel(m_sel),
    .o_req_stall(o_req_stall), .o_req_ack(o_req_ack), .o_req_miss(o_req_miss),
    .o_req_err(o_req_err), .o_req_rdata(o_req_rdata),
    .o_mem_stb(o_mem_stb), .o_mem_we(o_mem_we), .o_mem_addr(o_mem_addr),
    .o_mem_wdata(o_mem_wdata), .o_mem_sel(o_mem_sel),
    .i_mem_stall(mem_stall), .i_mem_ack(mem_ack), .i_mem_err(mem_err),
    .i_mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0, waits = 0;

  function automatic [31:0] mfun(input [29:0] a);
    return {2'b00, a} ^ 32'h5A5A_0000;
  endfunction
  function automatic [29:0] wa(input [19:0] pg, input [9:0] off);
    return {pg, off};
  endfunction
  function automatic [31:0] vword(input [19:0] pg, input [15:0] ctx, input [3:0] fl);
    return {pg, ctx[7:0], fl};
  endfunction
  function automatic [31:0] pword(input [19:0] pg, input [15:0] ctx);
    return {pg, ctx[15:8], 4'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: acknowledges one cycle after taking a strobe
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack   <= o_mem_stb & ~mem_stall;
      mem_rdata <= (o_mem_stb & ~o_mem_we) ? mfun(o_mem_addr) : 32'h0;
    end
  end

  // scoreboard queues
  bit          q_miss [$];
  logic [31:0] q_data [$];
  string       q_tag  [$];
  logic [29:0] d_addr [$];
  bit          d_we   [$];
  logic [31:0] d_data [$];
  string       d_tag  [$];

  bit          pm;
  logic [31:0] pd;
  string       pt;
  logic [29:0] pa;
  bit          pw;

  // master-side monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && (o_req_ack || o_req_miss)) begin
      if (q_miss.size() == 0) begin
        chk(0, "R5 unexpected master result", {30'b0, o_req_miss, o_req_ack}, 32'h0);
      end else begin
        pm = q_miss.pop_front(); pd = q_data.pop_front(); pt = q_tag.pop_front();
        chk(o_req_miss == pm && o_req_ack == !pm, pt, {30'b0, o_req_miss, o_req_ack},
            {30'b0, pm, !pm});
        chk(o_req_err == 1'b0, pt, {31'b0, o_req_err}, 32'h0);
        if (!pm) chk(o_req_rdata == pd, {pt, " R13 data"}, o_req_rdata, pd);
      end
    end
  end

  // memory-side monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && o_mem_stb && !mem_stall) begin
      if (d_addr.size() == 0) begin
        chk(0, "R5 unexpected memory strobe", {2'b0, o_mem_addr}, 32'h0);
      end else begin
        pa = d_addr.pop_front(); pw = d_we.pop_front(); pd = d_data.pop_front();
        pt = d_tag.pop_front();
        chk(o_mem_addr == pa, {pt, " addr"}, {2'b0, o_mem_addr}, {2'b0, pa});
        chk(o_mem_we == pw, {pt, " we"}, {31'b0, o_mem_we}, {31'b0, pw});
        if (pw) chk(o_mem_wdata == pd && o_mem_sel == 4'hF, {pt, " wdata"}, o_mem_wdata, pd);
      end
    end
  end

  // driver: pushes expectations, then presents one master strobe
  task automatic m_send(input bit we, input bit user, input bit exe, input [29:0] va,
                        input [31:0] wd, input bit miss, input [29:0] phys, input string tag);
    @(negedge clk);
    q_miss.push_back(miss);
    q_data.push_back(we ? 32'h0 : mfun(phys));
    q_tag.push_back(tag);
    if (!miss) begin
      d_addr.push_back(phys); d_we.push_back(we); d_data.push_back(wd); d_tag.push_back(tag);
    end
    m_stb = 1; m_we = we; m_user = user; m_exe = exe; m_addr = va; m_wdata = wd;
    #1;
    while (o_req_stall) begin
      waits++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic m_idle();
    @(negedge clk);
    m_stb = 0; m_user = 0; m_exe = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) @(negedge clk);
  endtask

  task automatic cfg_acc(input bit we, input [4:0] a, input [31:0] d, output [31:0] rd);
    @(negedge clk);
    c_stb = 1; c_we = we; c_addr = a; c_wdata = d;
    #1;
    while (o_cfg_stall) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    c_stb = 0;
    #1;
    chk(o_cfg_ack == 1'b1, "R2 ack one cycle after strobe", {31'b0, o_cfg_ack}, 32'h1);
    rd = o_cfg_rdata;
  endtask

  task automatic cfg_wr(input [4:0] a, input [31:0] d);
    logic [31:0] unused_rd;
    cfg_acc(1'b1, a, d, unused_rd);
  endtask

  task automatic cfg_rd(input [4:0] a, input [31:0] exp, input string tag);
    logic [31:0] rd;
    cfg_acc(1'b0, a, 32'h0, rd);
    chk(rd == exp, tag, rd, exp);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [19:0] PG_A = 20'hABCDE, PG_RO = 20'h00077, PG_X = 20'h00088;
  localparam logic [19:0] PP_A = 20'h00123, PP_RO = 20'h00200, PP_X = 20'h00300;
  localparam logic [15:0] CTX = 16'h1234;

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #2;
    chk({o_req_ack, o_req_miss, o_cfg_ack, o_mem_stb} == 4'b0, "R4 reset outputs idle",
        {28'b0, o_req_ack, o_req_miss, o_cfg_ack, o_mem_stb}, 32'h0);
    cfg_rd(5'd0, 32'hF32F_0000, "R1 control word after reset");

    // R4/R5: all-zero entries must not match vpn 0 with context 0
    m_send(0, 1, 0, 30'h5, 0, 1, 30'h0, "R4 R5 miss with empty buffer");
    m_idle();
    drain();
    cfg_rd(5'd1, 32'h14, "R5 status holds faulting byte address");

    cfg_wr(5'd0, 32'hFFFF_0000 | CTX);
    cfg_rd(5'd0, 32'hF32F_0000 | CTX, "R1 only context writable");

    // entry 0: plain page
    cfg_wr(5'd16, vword(PG_A, CTX, 4'b0000));
    cfg_wr(5'd17, pword(PP_A, CTX) | 32'h5);
    cfg_rd(5'd16, vword(PG_A, CTX, 4'b0000), "R4 virtual word readback");
    cfg_rd(5'd17, pword(PP_A, CTX), "R4 physical word readback low nibble zero");

    m_send(0, 1, 0, wa(PG_A, 10'h003), 0, 0, wa(PP_A, 10'h003), "R8 translated read");
    m_send(1, 1, 0, wa(PG_A, 10'h3FF), 32'hCAFE_F00D, 0, wa(PP_A, 10'h3FF), "R8 translated write");
    m_idle();
    drain();
    cfg_rd(5'd16, vword(PG_A, CTX, 4'b0001), "R11 accessed flag set after hit");

    // R3: setup stalls while a request is in lookup
    m_send(0, 1, 0, wa(PG_A, 10'h010), 0, 0, wa(PP_A, 10'h010), "R3 request for stall check");
    @(negedge clk);
    m_stb = 0; m_user = 0;
    #1;
    chk(o_cfg_stall == 1'b1, "R3 setup stall during lookup", {31'b0, o_cfg_stall}, 32'h1);
    drain();
    cfg_rd(5'd16, vword(PG_A, CTX, 4'b0001), "R11 accessed flag stays set");

    // entry 1: read-only page, entry 2: executable page
    cfg_wr(5'd18, vword(PG_RO, CTX, 4'b1000));
    cfg_wr(5'd19, pword(PP_RO, CTX));
    cfg_wr(5'd20, vword(PG_X, CTX, 4'b0100));
    cfg_wr(5'd21, pword(PP_X, CTX));
    m_send(0, 1, 0, wa(PG_RO, 10'h020), 0, 0, wa(PP_RO, 10'h020), "R6 read of read-only page");
    m_send(1, 1, 0, wa(PG_RO, 10'h021), 32'h1111, 1, 30'h0, "R6 write to read-only page");
    m_send(0, 1, 1, wa(PG_RO, 10'h022), 0, 1, 30'h0, "R7 fetch from non-exec page");
    m_send(0, 1, 1, wa(PG_X, 10'h023), 0, 0, wa(PP_X, 10'h023), "R7 fetch from exec page");
    m_idle();
    drain();

    // R12: both context halves must match
    cfg_wr(5'd0, 32'h0000_1334);
    m_send(0, 1, 0, wa(PG_A, 10'h004), 0, 1, 30'h0, "R12 high context half differs");
    m_idle();
    drain();
    cfg_wr(5'd0, 32'h0000_1235);
    m_send(0, 1, 0, wa(PG_A, 10'h004), 0, 1, 30'h0, "R12 low context half differs");
    m_idle();
    drain();
    cfg_wr(5'd0, {16'h0, CTX});
    m_send(0, 1, 0, wa(PG_A, 10'h004), 0, 0, wa(PP_A, 10'h004), "R12 matching context hits");

    // R10: pass-through when user mode is low
    m_send(1, 0, 0, wa(PG_RO, 10'h030), 32'h2222, 0, wa(PG_RO, 10'h030), "R10 pass-through write to read-only page");
    m_send(0, 0, 1, 30'h0001_2345, 0, 0, 30'h0001_2345, "R10 pass-through unmapped fetch");
    m_idle();
    drain();

    // R9: burst inside a page without stalls
    w0 = waits;
    for (int i = 0; i < 6; i++)
      m_send(0, 1, 0, wa(PG_A, 10'(i + 16'h40)), 0, 0, wa(PP_A, 10'(i + 16'h40)), "R9 burst read");
    m_idle();
    chk(waits == w0, "R9 burst accepted without stall", waits - w0, 32'h0);
    drain();

    // R9/R13: downstream stall in mid-burst
    w0 = waits;
    fork
      begin
        repeat (3) @(negedge clk);
        mem_stall = 1;
        repeat (2) @(negedge clk);
        mem_stall = 0;
      end
    join_none
    for (int i = 0; i < 6; i++)
      m_send(i[0], 1, 0, wa(PG_A, 10'(i + 16'h80)), 32'hB000 + i, 0, wa(PP_A, 10'(i + 16'h80)),
             "R9 R13 burst with memory stall");
    m_idle();
    chk(waits > w0, "R9 memory stall reaches master", waits - w0, 32'h1);
    drain();

    chk(q_miss.size() == 0 && d_addr.size() == 0, "R13 all results returned",
        q_miss.size() + d_addr.size(), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule